// File: doc/BRIEF.md
# Bi-Endian Load Data Aligner

This block formats the data returned by a load. It receives one naturally aligned memory doubleword, with the byte from the lowest address in the lowest input lane. It also receives the byte offset of the access inside that doubleword, an access size of 8, 16, 32 or 64 bits, an extend select and a run-time endianness select. From these it produces the addressed operand, right-justified in a register-wide value.

Little-endian requests go through a path that only shifts by the offset and then masks to the width. Big-endian requests go through a path that reverses the byte order and then picks, by access size, one of several copies of the word, each shifted by a different amount. Both paths feed one shared extension stage. The result and an error flag are registered once before they leave the block.

An access whose offset is not a multiple of its size would cross the doubleword. It is not split into parts. It is reported on the error output, and the data output is forced to zero.

Top module: `load_aligner`

## Requirements
- R1: Input bits [8k+7:8k] hold the memory byte at offset k. In little-endian mode (endianness select 0), the result is the byte at the offset in bits [7:0], the next byte up in bits [15:8], and so on up to the access width.
- R2: In big-endian mode (endianness select 1), the byte at the offset becomes the most significant byte of the operand, and each byte at a higher address is one byte less significant.
- R3: In little-endian mode, 8, 16 and 32-bit accesses at offset 0 return the low 8, 16 and 32 bits of the 64-bit access at offset 0.
- R4: In big-endian mode, a narrow access at offset (field offset + wide size − narrow size) returns the low bits of the wider access at the field offset.
- R5: The size code is 0=8, 1=16, 2=32, 3=64 bits. With the extend select at 0, every result bit above the access width is 0.
- R6: With the extend select at 1, every result bit above the access width equals the operand's top bit.
- R7: When the offset is not a multiple of the access size in bytes, the error output is 1 and the data output is all zeros. Otherwise the error output is 0.
- R8: The outputs change only on a rising clock edge and show the result for the inputs present at that edge. A synchronous active-high reset clears both outputs to 0.
- R9: A 64-bit access returns the full doubleword in the selected byte order, whatever the extend select is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dword_i | input | DATA_W (64) | Aligned memory doubleword; lane k is the byte at offset k |
| offset_i | input | OFFS_W (3) | Byte offset of the access |
| size_i | input | 2 | Access size code: 0=8, 1=16, 2=32, 3=64 bits |
| sext_i | input | 1 | 1 = sign-extend, 0 = zero-extend |
| big_endian_i | input | 1 | 1 = big-endian byte order, 0 = little-endian |
| data_o | output | DATA_W (64) | Registered right-justified operand |
| misalign_o | output | 1 | Registered error flag for an access that crosses the doubleword |

## Verification
The assertions assume that every input is driven to a known 0 or 1 at each rising edge, and that the size code only takes the four values listed in R5. They also assume that reset is held for at least one edge before they apply. The stimulus drives all inputs at falling edges, starting from time zero, and only ever uses legal size codes. Misaligned offsets are sent on purpose, so the error-flag and zeroed-data properties are exercised along with the aligned cases.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ld_size_e;

  localparam int SIZE_W = 2;
endpackage

// File: rtl/ldalign_mask.sv
module ldalign_mask #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int SIZE_W = ldalign_pkg::SIZE_W
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] top_o
);
  // One lane-enable per byte; width in bytes is 1 << size.
  always_comb begin
    mask_o = '0;
    for (int b = 0; b < LANES; b++) begin
      if (b < (1 << size_i)) mask_o[b*BYTE_W +: BYTE_W] = '1;
    end
    top_o = mask_o & ~(mask_o >> 1);
  end
endmodule

// File: rtl/ldalign_le_path.sv
module ldalign_le_path #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] raw_o
);
  // Same lane placement for every width: only the mask depends on size.
  always_comb raw_o = (word_i >> (BYTE_W * int'(offset_i))) & mask_i;
endmodule

// File: rtl/ldalign_be_path.sv
module ldalign_be_path #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFFS_W = $clog2(LANES),
  localparam int NSIZES = OFFS_W + 1,
  localparam int SIZE_W = ldalign_pkg::SIZE_W
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] raw_o
);
  logic [DATA_W-1:0] rev;
  logic [DATA_W-1:0] shifted [NSIZES];

  // Lowest address ends up most significant.
  for (genvar g = 0; g < LANES; g++) begin : g_rev
    assign rev[(LANES-1-g)*BYTE_W +: BYTE_W] = word_i[g*BYTE_W +: BYTE_W];
  end

  // One copy per width, each with its own right shift.
  for (genvar s = 0; s < NSIZES; s++) begin : g_copy
    localparam int NBYTES = 1 << s;
    always_comb begin
      if (int'(offset_i) > LANES - NBYTES) shifted[s] = '0;
      else shifted[s] = rev >> (BYTE_W * (LANES - NBYTES - int'(offset_i)));
    end
  end

  always_comb raw_o = shifted[size_i] & mask_i;
endmodule

// File: rtl/ldalign_extend.sv
module ldalign_extend #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] top_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] ext_o
);
  logic sign;
  always_comb begin
    sign  = |(raw_i & top_i);
    ext_o = (raw_i & mask_i) | ((sext_i && sign) ? ~mask_i : '0);
  end
endmodule

// File: rtl/load_aligner.sv
module load_aligner #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFFS_W = $clog2(LANES),
  localparam int SIZE_W = ldalign_pkg::SIZE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dword_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              sext_i,
  input  logic              big_endian_i,
  output logic [DATA_W-1:0] data_o,
  output logic              misalign_o
);
  logic [DATA_W-1:0] width_mask, top_bit, le_raw, be_raw, sel_raw, ext_val;
  logic [OFFS_W-1:0] align_bits;
  logic              misalign;
  logic [DATA_W-1:0] result;

  ldalign_mask #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) mask_i (
    .size_i(size_i), .mask_o(width_mask), .top_o(top_bit)
  );

  ldalign_le_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) le_i (
    .word_i(dword_i), .offset_i(offset_i), .mask_i(width_mask), .raw_o(le_raw)
  );

  ldalign_be_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) be_i (
    .word_i(dword_i), .offset_i(offset_i), .size_i(size_i),
    .mask_i(width_mask), .raw_o(be_raw)
  );

  always_comb sel_raw = big_endian_i ? be_raw : le_raw;

  ldalign_extend #(.DATA_W(DATA_W)) ext_i (
    .raw_i(sel_raw), .mask_i(width_mask), .top_i(top_bit),
    .sext_i(sext_i), .ext_o(ext_val)
  );

  always_comb begin
    align_bits = OFFS_W'((32'd1 << size_i) - 32'd1);
    misalign   = |(offset_i & align_bits);
    result     = misalign ? '0 : ext_val;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        data_o     <= '0;
        misalign_o <= 1'b0;
      end else begin
        data_o     <= result;
        misalign_o <= misalign;
      end
    end

    assert_err_zero_R7: assert property (@(posedge clk) disable iff (rst)
      misalign_o |-> (data_o == '0));
    assert_odd_offset_R7: assert property (@(posedge clk) disable iff (rst)
      (offset_i[0] && size_i != SIZE_W'(0)) |=> misalign_o);
    assert_zext_R5: assert property (@(posedge clk) disable iff (rst)
      (size_i == SIZE_W'(0) && !sext_i) |=> (data_o[DATA_W-1:BYTE_W] == '0));
    assert_sext_R6: assert property (@(posedge clk) disable iff (rst)
      (size_i == SIZE_W'(0) && sext_i) |=>
        (data_o[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){data_o[BYTE_W-1]}}));
    assert_le_full_R1: assert property (@(posedge clk) disable iff (rst)
      (size_i == SIZE_W'(3) && offset_i == '0 && !big_endian_i) |=>
        (data_o == $past(dword_i)));
    assert_be_first_R2: assert property (@(posedge clk) disable iff (rst)
      (size_i == SIZE_W'(3) && offset_i == '0 && big_endian_i) |=>
        (data_o[BYTE_W-1:0] == $past(dword_i[DATA_W-1 -: BYTE_W])));
  end else begin : g_comb
    always_comb begin
      data_o     = result;
      misalign_o = misalign;
    end
  end
endmodule

// File: tb/load_aligner_tb_top.sv
module load_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dword = '0;
  logic [2:0]  offset = '0;
  logic [1:0]  size = '0;
  logic        sext = 1'b0;
  logic        be = 1'b0;
  logic [63:0] data_o;
  logic        misalign_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  load_aligner dut_i (
    .clk(clk), .rst(rst), .dword_i(dword), .offset_i(offset), .size_i(size),
    .sext_i(sext), .big_endian_i(be), .data_o(data_o), .misalign_o(misalign_o)
  );

  // {be, size, offset, sext, err, expected}
  localparam logic [63:0] MEM0 = 64'h8877_6655_4433_2211;
  localparam logic [71:0] VECS [10] = '{
    {1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 64'h0000_0000_0000_0011},
    {1'b0, 2'd1, 3'd2, 1'b1, 1'b0, 64'h0000_0000_0000_4433},
    {1'b0, 2'd2, 3'd4, 1'b1, 1'b0, 64'hFFFF_FFFF_8877_6655},
    {1'b0, 2'd3, 3'd0, 1'b1, 1'b0, 64'h8877_6655_4433_2211},
    {1'b1, 2'd0, 3'd7, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF88},
    {1'b1, 2'd1, 3'd0, 1'b0, 1'b0, 64'h0000_0000_0000_1122},
    {1'b1, 2'd2, 3'd4, 1'b0, 1'b0, 64'h0000_0000_5566_7788},
    {1'b1, 2'd3, 3'd0, 1'b1, 1'b0, 64'h1122_3344_5566_7788},
    {1'b1, 2'd1, 3'd3, 1'b0, 1'b1, 64'h0},
    {1'b0, 2'd2, 3'd2, 1'b1, 1'b1, 64'h0}
  };

  // Byte-array reference model: returns {err, data}.
  function automatic logic [64:0] ref_load(input logic [63:0] w, input logic b,
                                           input logic [1:0] sz, input logic [2:0] off,
                                           input logic sx);
    logic [7:0]  mem [8];
    logic [63:0] v;
    int nb;
    nb = 1 << sz;
    for (int i = 0; i < 8; i++) mem[i] = w[i*8 +: 8];
    if ((int'(off) % nb) != 0) return {1'b1, 64'h0};
    v = '0;
    for (int i = 0; i < nb; i++) begin
      if (!b) v[i*8 +: 8] = mem[int'(off) + i];
      else    v = (v << 8) | 64'(mem[int'(off) + i]);
    end
    if (sx && nb < 8 && v[nb*8-1]) begin
      for (int i = nb*8; i < 64; i++) v[i] = 1'b1;
    end
    return {1'b0, v};
  endfunction

  task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got err=%0b data=%h expected err=%0b data=%h",
               tag, got[64], got[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic apply(input logic [63:0] w, input logic b, input logic [1:0] sz,
                       input logic [2:0] off, input logic sx);
    @(negedge clk);
    dword = w; be = b; size = sz; offset = off; sext = sx;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] words [4];
    logic [64:0] full, part;
    words[0] = MEM0;
    words[1] = 64'h0123_4567_89AB_CDEF;
    words[2] = 64'hF0E1_D2C3_B4A5_9687;
    words[3] = 64'h7F80_01FE_00FF_8000;

    // R8: reset clears outputs
    dword = 64'hFFFF_FFFF_FFFF_FFFF; size = 2'd3;
    repeat (2) @(negedge clk);
    check("R8 reset", {misalign_o, data_o}, 65'h0);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < 10; i++) begin
      logic [71:0] v;
      v = VECS[i];
      apply(MEM0, v[71], v[70:69], v[68:66], v[65]);
      check(v[64] ? "R7 table" : (v[71] ? "R2 table" : "R1 table"),
            {misalign_o, data_o}, v[64:0]);
    end

    // Exhaustive sweep against byte-array model
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 8; o++)
            for (int x = 0; x < 2; x++) begin
              apply(words[w], b[0], s[1:0], o[2:0], x[0]);
              check(x ? "R1/R2/R6/R7 sweep" : "R1/R2/R5/R7 sweep",
                    {misalign_o, data_o},
                    ref_load(words[w], b[0], s[1:0], o[2:0], x[0]));
            end

    // R3: little-endian prefixes share the base offset
    apply(words[2], 1'b0, 2'd3, 3'd0, 1'b0);
    full = {misalign_o, data_o};
    for (int s = 0; s < 3; s++) begin
      apply(words[2], 1'b0, s[1:0], 3'd0, 1'b0);
      part = {1'b0, full[63:0] & ((64'd1 << (8 << s)) - 64'd1)};
      check("R3 prefix", {misalign_o, data_o}, part);
    end

    // R4: big-endian narrow inside wide field
    apply(words[1], 1'b1, 2'd2, 3'd4, 1'b0);
    full = {misalign_o, data_o};
    apply(words[1], 1'b1, 2'd1, 3'd6, 1'b0);
    check("R4 half in word", {misalign_o, data_o}, {1'b0, 48'h0, full[15:0]});
    apply(words[1], 1'b1, 2'd0, 3'd7, 1'b0);
    check("R4 byte in word", {misalign_o, data_o}, {1'b0, 56'h0, full[7:0]});

    // R9: extend select has no effect on 64-bit access
    apply(words[2], 1'b1, 2'd3, 3'd0, 1'b1);
    check("R9 dword sext", {misalign_o, data_o}, {1'b0, 64'h8796_A5B4_C3D2_E1F0});
    apply(words[2], 1'b1, 2'd3, 3'd0, 1'b0);
    check("R9 dword zext", {misalign_o, data_o}, {1'b0, 64'h8796_A5B4_C3D2_E1F0});

    // R8: output holds until the next rising edge
    @(negedge clk);
    dword = MEM0; be = 1'b0; size = 2'd0; offset = 3'd0; sext = 1'b0;
    #2;
    check("R8 hold", {misalign_o, data_o}, {1'b0, 64'h8796_A5B4_C3D2_E1F0});
    @(negedge clk);
    check("R8 update", {misalign_o, data_o}, {1'b0, 64'h11});

    // R8: synchronous reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset again", {misalign_o, data_o}, 65'h0);
    rst = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule